// File: doc/BRIEF.md
# Reserved-Opcode Dummy-Cycle Sequencer

This block plays out the bus activity of the opcodes that an 8-bit CMOS processor core leaves without an architectural meaning. Those opcodes change no register and no flag. They still have a length in bytes and a cycle cost, and they still place reads on the memory bus. Those reads matter whenever a memory-mapped device sits at the address being read. The surrounding core hands the sequencer an opcode and the address it was fetched from, with a one-cycle start strobe. The sequencer then owns the read port for the class-specific number of cycles. On the final cycle it pulses done and reports the instruction length, so the core can step its program counter.

An opcode outside the reserved classes is not run. It is flagged as unsupported after a single cycle, with no bus traffic, so the core can handle it some other way.

Top module: `rsvd_nop_seq`

## Requirements
- R1: The first cycle after an accepted start reads the opcode address captured at the start. Operand bytes are read from the following consecutive addresses, one per cycle. The read-data byte is taken in the same cycle the read is issued.
- R2: An opcode whose two low bits are 11 is 1 byte long and takes 1 cycle, a single read of the opcode address.
- R3: An opcode whose five low bits are 00010, except those whose three high bits are 101, is 2 bytes long and takes 2 cycles: the opcode address, then the operand address.
- R4: Opcode 0x44 is 2 bytes long and takes 3 cycles. Its third read goes to the zero-page address {0x00, operand}.
- R5: Opcodes 0x54, 0xD4 and 0xF4 (bit pattern x1x10100 with 0x74 excluded) are 2 bytes long and take 4 cycles. Reads three and four both go to {0x00, operand}. Opcode 0x74 is unsupported.
- R6: Opcodes 0xDC and 0xFC are 3 bytes long and take 4 cycles. The fourth read goes to {high operand, low operand}.
- R7: Opcode 0x5C is 3 bytes long and takes 8 cycles. After its three fetches it reads {0xFF, low operand} once and then 0xFFFF four times.
- R8: Opcode and operand fetch addresses wrap modulo 2^16 past 0xFFFF.
- R9: done is high for exactly one cycle, the last cycle of a sequence. len shows the byte count (1 to 3) only in that cycle and is 0 in every other cycle.
- R10: A start that arrives while busy is high is ignored, including in the done cycle. The running sequence continues unchanged and busy falls after done.
- R11: Any other opcode completes in one cycle with done and unsup high, no read, and len equal to 0.
- R12: After reset the sequencer is idle: busy, rd, done and unsup are low and len is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| opcode_i | input | 8 | Opcode to run |
| pc_i | input | ADDR_W (16) | Address the opcode was fetched from |
| rd_o | output | 1 | Read strobe |
| addr_o | output | ADDR_W (16) | Read address, 0 when rd_o is low |
| rdata_i | input | DATA_W (8) | Read data, valid in the cycle rd_o is high |
| busy_o | output | 1 | Sequence in progress, including the done cycle |
| done_o | output | 1 | Final-cycle pulse |
| len_o | output | 2 | Instruction length in bytes, valid with done_o |
| unsup_o | output | 1 | Opcode is outside the reserved classes |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 16-bit address and an all-ones high page. Those values keep the whole opcode space small enough to sweep. Every one of the 256 opcodes is run against a model of the class rules, which exercises every class boundary, including the excluded 0x74 and the 101-prefixed immediate slot. The 16-bit address makes it easy to start sequences at 0xFFFE and 0xFFFF. There, operand fetches wrap to page zero, and the high-page reads of 0x5C meet the top of memory. Starts are also held high across whole sequences to show that they are ignored.

// File: rtl/rsvd_nop_pkg.sv
// Shared types and class properties for the reserved-opcode sequencer.
// Assumes at most eight bus cycles for any class.
package rsvd_nop_pkg;

    typedef enum logic [2:0] {
        K_UNSUP = 3'd0,
        K_ONE   = 3'd1,
        K_IMM2  = 3'd2,
        K_ZP3   = 3'd3,
        K_ZPX4  = 3'd4,
        K_ABS4  = 3'd5,
        K_FAR8  = 3'd6
    } nop_kind_e;

    localparam int MAX_CYC = 8;
    localparam int STEP_W  = $clog2(MAX_CYC);
    localparam int CYC_W   = STEP_W + 1;

    // Byte length of a class; zero for an unsupported opcode.
    function automatic logic [1:0] kind_len(nop_kind_e k);
        case (k)
            K_ONE:                  return 2'd1;
            K_IMM2, K_ZP3, K_ZPX4:  return 2'd2;
            K_ABS4, K_FAR8:         return 2'd3;
            default:                return 2'd0;
        endcase
    endfunction

    // Total bus cycles of a class, opcode fetch included.
    function automatic logic [CYC_W-1:0] kind_cycles(nop_kind_e k);
        case (k)
            K_ONE:          return CYC_W'(1);
            K_IMM2:         return CYC_W'(2);
            K_ZP3:          return CYC_W'(3);
            K_ZPX4, K_ABS4: return CYC_W'(4);
            K_FAR8:         return CYC_W'(MAX_CYC);
            default:        return CYC_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/rsvd_nop_decode.sv
// Maps an opcode to its reserved class. Purely combinational.
// Assumes the caller only latches the result when a start is accepted.
module rsvd_nop_decode
    import rsvd_nop_pkg::*;
(
    input  logic [7:0] opcode,
    output nop_kind_e  kind
);

    // Priority match of the class bit patterns.
    always_comb begin
        if (opcode[1:0] == 2'b11)
            kind = K_ONE;
        else if (opcode[4:0] == 5'b00010 && opcode[7:5] != 3'b101)
            kind = K_IMM2;
        else if (opcode == 8'h44)
            kind = K_ZP3;
        else if (opcode[6] && opcode[4:0] == 5'b10100 && opcode != 8'h74)
            kind = K_ZPX4;
        else if (opcode[7:6] == 2'b11 && opcode[4:0] == 5'b11100)
            kind = K_ABS4;
        else if (opcode == 8'h5C)
            kind = K_FAR8;
        else
            kind = K_UNSUP;
    end

endmodule

// File: rtl/rsvd_nop_step.sv
// Cycle index counter of a running sequence.
// Assumes launch and advance are never high together.
module rsvd_nop_step #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic         advance,
    output logic [W-1:0] step
);

    // Restart at zero on launch, count up while advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (launch)
            step <= '0;
        else if (advance)
            step <= step + W'(1);
    end

endmodule

// File: rtl/rsvd_nop_addr.sv
// Read address of each cycle, from the class, the cycle index and the operands.
// Assumes the operands were captured in the cycles where they were read.
module rsvd_nop_addr
    import rsvd_nop_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] HI_PAGE = '1,
    localparam int               ADDR_W  = 2 * DATA_W
) (
    input  nop_kind_e           kind,
    input  logic [STEP_W-1:0]   step,
    input  logic [ADDR_W-1:0]   base,
    input  logic [DATA_W-1:0]   op_lo,
    input  logic [DATA_W-1:0]   op_hi,
    output logic [ADDR_W-1:0]   addr
);

    localparam logic [DATA_W-1:0] ZERO_PAGE = '0;

    logic three_byte;
    assign three_byte = (kind == K_ABS4) || (kind == K_FAR8);

    // Address mux over the cycle index.
    always_comb begin
        case (step)
            STEP_W'(0): addr = base;
            STEP_W'(1): addr = base + ADDR_W'(1);
            STEP_W'(2): addr = three_byte ? base + ADDR_W'(2) : {ZERO_PAGE, op_lo};
            STEP_W'(3): begin
                case (kind)
                    K_ABS4:  addr = {op_hi, op_lo};
                    K_FAR8:  addr = {HI_PAGE, op_lo};
                    default: addr = {ZERO_PAGE, op_lo};
                endcase
            end
            default:    addr = {HI_PAGE, HI_PAGE};
        endcase
    end

endmodule

// File: rtl/rsvd_nop_seq.sv
// Runs the bus cycles of reserved opcodes: the opcode re-read, the operand fetches
// and the dummy reads. It pulses done with the length on the last cycle.
// Assumes read data is valid in the same cycle as rd_o, and that the core
// holds off the bus while busy_o is high.
module rsvd_nop_seq
    import rsvd_nop_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] HI_PAGE = '1,
    localparam int               ADDR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        len_o,
    output logic              unsup_o
);

    nop_kind_e           dec_kind;
    nop_kind_e           kind_q;
    logic                busy_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [DATA_W-1:0]   lo_q;
    logic [DATA_W-1:0]   hi_q;
    logic [STEP_W-1:0]   step;
    logic [ADDR_W-1:0]   seq_addr;
    logic                launch;
    logic                last;
    logic                advance;
    logic                active_rd;

    rsvd_nop_decode u_decode (
        .opcode (opcode_i),
        .kind   (dec_kind)
    );

    rsvd_nop_step #(.W(STEP_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .advance (advance),
        .step    (step)
    );

    rsvd_nop_addr #(.DATA_W(DATA_W), .HI_PAGE(HI_PAGE)) u_addr (
        .kind  (kind_q),
        .step  (step),
        .base  (pc_q),
        .op_lo (lo_q),
        .op_hi (hi_q),
        .addr  (seq_addr)
    );

    assign launch    = start_i && !busy_q;
    assign last      = busy_q && ((kind_q == K_UNSUP) ||
                       (CYC_W'(step) == kind_cycles(kind_q) - CYC_W'(1)));
    assign advance   = busy_q && !last;
    assign active_rd = busy_q && (kind_q != K_UNSUP);

    // Sequence ownership: accept a start when idle, release after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= K_UNSUP;
            pc_q   <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            kind_q <= dec_kind;
            pc_q   <= pc_i;
        end else if (last) begin
            busy_q <= 1'b0;
        end
    end

    // Operand capture from the fetch cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (active_rd) begin
            if (step == STEP_W'(1))
                lo_q <= rdata_i;
            if (step == STEP_W'(2) && (kind_q == K_ABS4 || kind_q == K_FAR8))
                hi_q <= rdata_i;
        end
    end

    // Port drive.
    always_comb begin
        rd_o    = active_rd;
        addr_o  = active_rd ? seq_addr : '0;
        busy_o  = busy_q;
        done_o  = last;
        len_o   = last ? kind_len(kind_q) : 2'd0;
        unsup_o = last && (kind_q == K_UNSUP);
    end

endmodule

// File: rtl/rsvd_nop_seq_chk.sv
// Port-level temporal checks of the sequencer, attached by bind.
// Assumes reset is held low from time zero.
module rsvd_nop_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              rd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        len_o,
    input logic              unsup_o
);

    p_fetch_at_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && (unsup_o || (rd_o && addr_o == $past(pc_i)))));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_len_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (len_o == 2'd0));

    p_len_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !unsup_o) |-> (len_o != 2'd0));

    p_run_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_unsup_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> (done_o && !rd_o && len_o == 2'd0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_o && !done_o && !unsup_o));

endmodule

bind rsvd_nop_seq rsvd_nop_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .pc_i    (pc_i),
    .rd_o    (rd_o),
    .addr_o  (addr_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .len_o   (len_o),
    .unsup_o (unsup_o)
);

// File: tb/rsvd_nop_seq_tb.sv
module rsvd_nop_seq_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int KU = 0, K1 = 1, KI = 2, KZ = 3, KX = 4, KA = 5, KF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [15:0] pc_i = 16'h0000;
    logic        rd_o;
    logic [15:0] addr_o;
    logic [7:0]  rdata_i;
    logic        busy_o, done_o, unsup_o;
    logic [1:0]  len_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rsvd_nop_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .pc_i(pc_i), .rd_o(rd_o), .addr_o(addr_o), .rdata_i(rdata_i),
        .busy_o(busy_o), .done_o(done_o), .len_o(len_o), .unsup_o(unsup_o)
    );

    function automatic logic [7:0] mem_f(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign rdata_i = mem_f(addr_o);

    function automatic int ref_kind(logic [7:0] op);
        if (op[1:0] == 2'b11) return K1;
        if (op[4:0] == 5'b00010 && op[7:5] != 3'b101) return KI;
        if (op == 8'h44) return KZ;
        if (op == 8'h54 || op == 8'hD4 || op == 8'hF4) return KX;
        if (op == 8'hDC || op == 8'hFC) return KA;
        if (op == 8'h5C) return KF;
        return KU;
    endfunction

    function automatic string kind_req(int k);
        case (k)
            K1: return "R2";
            KI: return "R3";
            KZ: return "R4";
            KX: return "R5";
            KA: return "R6";
            KF: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one opcode and checks timing, addresses, length and flags.
    task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                          input bit inject, input string extra);
        int k, ecyc, elen, n, addr_bad, first_act, first_exp;
        logic [15:0] ea [8];
        logic [7:0] lo, hi;
        string req;
        bit seen_unsup;
        logic [1:0] got_len;
        k    = ref_kind(op);
        req  = {kind_req(k), extra};
        lo   = mem_f(pc + 16'd1);
        hi   = mem_f(pc + 16'd2);
        for (int i = 0; i < 8; i++) ea[i] = 16'hFFFF;
        ea[0] = pc;
        ea[1] = pc + 16'd1;
        case (k)
            K1: begin ecyc = 1; elen = 1; end
            KI: begin ecyc = 2; elen = 2; end
            KZ: begin ecyc = 3; elen = 2; ea[2] = {8'h00, lo}; end
            KX: begin ecyc = 4; elen = 2; ea[2] = {8'h00, lo}; ea[3] = {8'h00, lo}; end
            KA: begin ecyc = 4; elen = 3; ea[2] = pc + 16'd2; ea[3] = {hi, lo}; end
            KF: begin ecyc = 8; elen = 3; ea[2] = pc + 16'd2; ea[3] = {8'hFF, lo}; end
            default: begin ecyc = 1; elen = 0; end
        endcase
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; pc_i = pc;
        @(negedge clk);
        if (inject) begin opcode_i = 8'h03; pc_i = 16'h2222; end
        else start_i = 1'b0;
        n = 0; addr_bad = 0; first_act = 0; first_exp = 0;
        seen_unsup = 1'b0; got_len = 2'd0;
        for (int c = 0; c < 12; c++) begin
            n++;
            if (k == KU) begin
                if (rd_o) addr_bad++;
            end else if (!rd_o || (c < 8 && addr_o != ea[c])) begin
                if (addr_bad == 0) begin first_act = addr_o; first_exp = ea[c < 8 ? c : 7]; end
                addr_bad++;
            end
            if (c == 0 && k != KU)
                chk(rd_o && addr_o == pc, "R1", "opcode re-read address", addr_o, pc);
            seen_unsup = unsup_o;
            got_len = len_o;
            if (!done_o && len_o != 2'd0)
                chk(1'b0, "R9", "len outside done", len_o, 0);
            if (done_o) break;
            @(negedge clk);
        end
        chk(n == ecyc, req, "cycle count", n, ecyc);
        chk(got_len == 2'(elen), {"R9 ", req}, "length at done", got_len, elen);
        chk(seen_unsup == (k == KU), {"R11 ", req}, "unsupported flag", seen_unsup, k == KU);
        chk(addr_bad == 0, {"R1 ", req}, "read address sequence", first_act, first_exp);
        @(negedge clk);
        chk(!busy_o && !rd_o && !done_o, inject ? "R10" : "R9", "idle after done",
            {busy_o, rd_o, done_o}, 0);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy_o && !rd_o && !done_o && !unsup_o && len_o == 2'd0, "R12",
            "reset state", {busy_o, rd_o, done_o, unsup_o, len_o}, 0);
    endtask

    task automatic t_one();    run_op(8'h03, 16'h0400, 0, ""); run_op(8'h7F, 16'h1234, 0, "");
                               run_op(8'hFB, 16'h8000, 0, ""); endtask
    task automatic t_imm();    run_op(8'h02, 16'h0300, 0, ""); run_op(8'hE2, 16'h5A5A, 0, "");
                               run_op(8'hA2, 16'h0300, 0, " R3"); endtask
    task automatic t_zp3();    run_op(8'h44, 16'h0210, 0, ""); run_op(8'h44, 16'hC0DE, 0, ""); endtask
    task automatic t_zpx();    run_op(8'h54, 16'h0700, 0, ""); run_op(8'hD4, 16'h0701, 0, "");
                               run_op(8'hF4, 16'h3456, 0, ""); run_op(8'h74, 16'h0700, 0, " R5"); endtask
    task automatic t_abs();    run_op(8'hDC, 16'h1000, 0, ""); run_op(8'hFC, 16'hABCD, 0, ""); endtask
    task automatic t_far();    run_op(8'h5C, 16'h2000, 0, ""); run_op(8'h5C, 16'h7F10, 0, ""); endtask
    task automatic t_wrap();   run_op(8'hFC, 16'hFFFE, 0, " R8"); run_op(8'h5C, 16'hFFFF, 0, " R8");
                               run_op(8'h44, 16'hFFFF, 0, " R8"); endtask
    task automatic t_busy();   run_op(8'h5C, 16'h4000, 1, " R10"); run_op(8'hDC, 16'h4100, 1, " R10");
                               run_op(8'hEA, 16'h4200, 1, " R10"); endtask
    task automatic t_unsup();  run_op(8'hA9, 16'h0100, 0, ""); run_op(8'hEA, 16'h0100, 0, "");
                               run_op(8'h00, 16'h0100, 0, ""); endtask
    task automatic t_sweep();
        for (int o = 0; o < 256; o++) run_op(8'(o), {8'(o), 8'(~o)}, 0, " sweep");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_one();
        t_imm();
        t_zp3();
        t_zpx();
        t_abs();
        t_far();
        t_wrap();
        t_busy();
        t_unsup();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule